// File: doc/BRIEF.md
# Supply Supervisor Reset Controller

This block turns a digital supply-good indication, an active-low push-button request and the sensed level of the active-low reset pin into one system reset. The reset appears on two outputs of opposite polarity. The active-high output models the drive enable of the high-going pin. The active-low output models an open-drain pin: a low level means the pull-down is on. Once every cause has cleared, the block keeps reset asserted for a fixed number of clock cycles. A cause that returns during that wait starts the wait again from zero.

The analog comparator sits outside the block and delivers its result as `supply_ok`, already synchronous to `clk`. The push-button input and the pin sense are asynchronous, so each goes through a two-flop synchronizer. The button is then debounced on a divided sample tick. The board can pull the active-low pin down from outside, and the block treats that as a trigger for a full reset. While the block drives the pin itself, it ignores the pin's level, and it keeps ignoring it for a short blanking window after release so that its own pull-down cannot retrigger it. A write-inhibit flag for the adjacent memory follows the inverted supply-good signal.

Top module: `rst_supervisor`

## Requirements
- R1: When `supply_ok` is sampled low on a rising edge, `rst_out` is 1 from that edge on and stays 1 while `supply_ok` remains low.
- R2: When `supply_ok` is first sampled high with no other cause present, `rst_out` falls on exactly the TIMEOUT_CYC+1-th rising edge from that one.
- R3: A low pulse on `man_rst_n` that spans fewer than DEB_TICKS consecutive debounce sample ticks has no effect on `rst_out`.
- R4: A debounced low on `man_rst_n` asserts `rst_out` and holds it while the input stays low. After release, reset lasts at least TIMEOUT_CYC further cycles.
- R5: `rst_out_n` is always the inverse of `rst_out`.
- R6: Pulling `rst_pin_sense_n` low from outside while reset is released asserts `rst_out` within four cycles, followed by a full timeout. The pin level is ignored while the block drives reset and for SYNC_STAGES+1 cycles after release.
- R7: `wr_inhibit` is 1 on the cycle after any edge that samples `supply_ok` low, and 0 on the cycle after an edge that samples it high.
- R8: A new reset cause during the timeout restarts the count, so release comes TIMEOUT_CYC+1 edges after the last cause clears.
- R9: While `rst_n` is low, and on the cycle after it rises, `rst_out` and `wr_inhibit` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low power-on reset of the logic |
| supply_ok | input | 1 | Comparator result, 1 when the supply is above threshold (synchronous) |
| man_rst_n | input | 1 | Push-button request, active low, asynchronous |
| rst_pin_sense_n | input | 1 | Sensed level of the active-low reset pin, asynchronous |
| rst_out | output | 1 | Reset, active high |
| rst_out_n | output | 1 | Reset, active low (low = pull-down enabled) |
| wr_inhibit | output | 1 | Memory write block, 1 while the supply is low |

## Verification
The checker tests every cycle that a low supply or a low debounced button forces reset on the next edge, that the two outputs stay complementary, that write-inhibit follows the supply, and that reset never falls unless the supply and button were both good on the cycle before. Other properties need whole scenarios, and only the bench can show them. These are the exact release cycle count, the restart of the timeout by a late cause, the rejection of short button glitches, and the pin loop, where the block's own pull-down must not lock it in reset while an outside pull-down still triggers one.

// File: rtl/rsv_pkg.sv
// Shared types for the reset supervisor.
// Assumes nothing beyond standard SystemVerilog.
package rsv_pkg;
    typedef enum logic [1:0] {
        ST_HOLD   = 2'd0,   // a reset cause is present
        ST_WAIT   = 2'd1,   // causes clear, timeout running
        ST_RUN    = 2'd2    // reset released
    } rsv_state_t;
endpackage

// File: rtl/rsv_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; the chain resets to RST_VAL.
module rsv_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/rsv_debounce.sv
// Debounce filter: the output takes a new level only after the synchronized
// input has differed from it on HOLD_TICKS consecutive sample ticks.
// Sample ticks come from a free-running divider of TICK_DIV cycles.
// Assumes a synchronized input; the output resets to the released level 1.
module rsv_debounce #(
    parameter int TICK_DIV   = 1000,
    parameter int HOLD_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int DW = (TICK_DIV   > 1) ? $clog2(TICK_DIV)   : 1;
    localparam int HW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;

    logic [DW-1:0] div_cnt;
    logic [HW-1:0] agree_cnt;
    logic          tick;

    assign tick = (div_cnt == DW'(TICK_DIV - 1));

    // free-running sample tick divider
    always_ff @(posedge clk) begin
        if (!rst_n || tick) div_cnt <= '0;
        else                div_cnt <= div_cnt + 1'b1;
    end

    // count consecutive ticks on which the input differs from the output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            agree_cnt <= '0;
            dout      <= 1'b1;
        end else if (tick) begin
            if (din == dout) begin
                agree_cnt <= '0;
            end else if (agree_cnt == HW'(HOLD_TICKS - 1)) begin
                agree_cnt <= '0;
                dout      <= din;
            end else begin
                agree_cnt <= agree_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rsv_core.sv
// Reset state machine with timeout counter and pin blanking.
// Any cause moves to HOLD; once all causes clear, reset is held for
// TIMEOUT_CYC+1 edges, and a cause during the wait restarts it.
// The pin sense counts as a cause only after reset has been released for
// BLANK_CYC cycles, so the block's own pull-down cannot retrigger it.
// Assumes all inputs are synchronous to clk.
module rsv_core
    import rsv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 20_000_000,
    parameter int BLANK_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic mr_ok,
    input  logic pin_low,
    output logic rst_active
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam int BW = $clog2(BLANK_CYC + 1);

    rsv_state_t    state;
    logic [TW-1:0] tmo_cnt;
    logic [BW-1:0] run_age;
    logic          pin_trig;
    logic          cause;

    assign pin_trig = pin_low && (state == ST_RUN) && (run_age == BW'(BLANK_CYC));
    assign cause    = !supply_ok || !mr_ok || pin_trig;

    // state transitions and timeout count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_HOLD;
            tmo_cnt <= '0;
        end else begin
            case (state)
                ST_HOLD: begin
                    tmo_cnt <= '0;
                    if (!cause) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (cause) begin
                        state   <= ST_HOLD;
                        tmo_cnt <= '0;
                    end else if (tmo_cnt == TW'(TIMEOUT_CYC - 1)) begin
                        state   <= ST_RUN;
                        tmo_cnt <= '0;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (cause) state <= ST_HOLD;
                end
                default: state <= ST_HOLD;
            endcase
        end
    end

    // age of the released state, saturating at the blanking length
    always_ff @(posedge clk) begin
        if (!rst_n || state != ST_RUN) run_age <= '0;
        else if (run_age != BW'(BLANK_CYC)) run_age <= run_age + 1'b1;
    end

    assign rst_active = (state != ST_RUN);
endmodule

// File: rtl/rst_supervisor.sv
// Top of the supply supervisor reset controller.
// Synchronizes the button and pin sense, debounces the button, runs the
// reset state machine and registers the memory write-inhibit flag.
// Assumes supply_ok is already synchronous to clk.
module rst_supervisor #(
    parameter int TIMEOUT_CYC = 20_000_000,
    parameter int DEB_DIV     = 10_000,
    parameter int DEB_TICKS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic man_rst_n,
    input  logic rst_pin_sense_n,
    output logic rst_out,
    output logic rst_out_n,
    output logic wr_inhibit
);
    logic mr_sync;
    logic mr_clean;
    logic pin_sync;
    logic rst_active;

    rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_mr_sync (
        .clk(clk), .rst_n(rst_n), .d_async(man_rst_n), .q_sync(mr_sync)
    );

    rsv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_pin_sync (
        .clk(clk), .rst_n(rst_n), .d_async(rst_pin_sense_n), .q_sync(pin_sync)
    );

    rsv_debounce #(.TICK_DIV(DEB_DIV), .HOLD_TICKS(DEB_TICKS)) i_mr_deb (
        .clk(clk), .rst_n(rst_n), .din(mr_sync), .dout(mr_clean)
    );

    rsv_core #(.TIMEOUT_CYC(TIMEOUT_CYC), .BLANK_CYC(SYNC_STAGES + 1)) i_core (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_ok(mr_clean),
        .pin_low(!pin_sync), .rst_active(rst_active)
    );

    // write-inhibit follows the supply, asserted from power-on
    always_ff @(posedge clk) begin
        if (!rst_n) wr_inhibit <= 1'b1;
        else        wr_inhibit <= !supply_ok;
    end

    assign rst_out   = rst_active;
    assign rst_out_n = !rst_active;
endmodule

// File: rtl/rsv_checker.sv
// Cycle-level properties of the reset supervisor, bound to the top.
module rsv_checker (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic mr_level,
    input logic rst_out,
    input logic rst_out_n,
    input logic wr_inhibit
);
    p_polarity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == !rst_out_n);

    p_supply_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> rst_out);

    p_manual_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_level |=> rst_out);

    p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> wr_inhibit);

    p_release_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> ($past(supply_ok) && $past(mr_level)));

    p_por_r9: assert property (@(posedge clk)
        !rst_n |=> (rst_out && wr_inhibit));
endmodule

bind rst_supervisor rsv_checker i_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_level(mr_clean),
    .rst_out(rst_out), .rst_out_n(rst_out_n), .wr_inhibit(wr_inhibit)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;
    localparam int T   = 20;
    localparam int DIV = 4;
    localparam int N   = 3;
    localparam int NV  = 10;

    // vector: {supply, man_n, force, hold[7:0], exp_rst, exp_inh}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 8'd5,  1'b1, 1'b1},
        {1'b1, 1'b1, 1'b0, 8'd40, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 8'd3,  1'b1, 1'b1},
        {1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd30, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'd30, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd40, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b1, 8'd5,  1'b1, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd40, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic man_rst_n = 1'b1;
    logic force_ext = 1'b0;
    logic rst_out, rst_out_n, wr_inhibit;
    logic pin_level;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    // open-drain pin: low when the block or the outside pulls it
    assign pin_level = rst_out_n && !force_ext;

    rst_supervisor #(.TIMEOUT_CYC(T), .DEB_DIV(DIV), .DEB_TICKS(N), .SYNC_STAGES(2))
    i_rst_supervisor (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
        .rst_pin_sense_n(pin_level), .rst_out(rst_out), .rst_out_n(rst_out_n),
        .wr_inhibit(wr_inhibit)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // count edges until rst_out falls; inputs changed at the previous negedge
    task automatic edges_to_release(output int n);
        n = 0;
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            n++;
            if (!rst_out) break;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        int n;
        // R9: outputs during and right after logic reset
        cycles(3);
        check("R9 rst_out in reset", int'(rst_out), 1);
        check("R9 wr_inhibit in reset", int'(wr_inhibit), 1);
        @(negedge clk) rst_n = 1'b1;
        cycles(1);
        check("R9 rst_out after reset", int'(rst_out), 1);
        check("R9 wr_inhibit after reset", int'(wr_inhibit), 1);

        // table walk: R1 R2 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            supply_ok = VEC[v][12];
            man_rst_n = VEC[v][11];
            force_ext = VEC[v][10];
            cycles(int'(VEC[v][9:2]));
            check($sformatf("R1/R4/R6 rst_out vec %0d", v), int'(rst_out), int'(VEC[v][1]));
            check($sformatf("R5 rst_out_n vec %0d", v), int'(rst_out_n), int'(!VEC[v][1]));
            check($sformatf("R7 wr_inhibit vec %0d", v), int'(wr_inhibit), int'(VEC[v][0]));
        end

        // R2: exact release edge after supply recovers
        @(negedge clk) supply_ok = 1'b0;
        cycles(3);
        @(negedge clk) supply_ok = 1'b1;
        edges_to_release(n);
        check("R2 release edge count", n, T + 1);

        // R8: a supply dip during the timeout restarts it
        @(negedge clk) supply_ok = 1'b0;
        cycles(2);
        @(negedge clk) supply_ok = 1'b1;
        cycles(10);
        @(negedge clk) supply_ok = 1'b0;
        @(negedge clk) supply_ok = 1'b1;
        edges_to_release(n);
        check("R8 restart edge count", n, T + 1);

        // R3: glitch shorter than the filter window is ignored
        cycles(5);
        @(negedge clk) man_rst_n = 1'b0;
        cycles(DIV);
        @(negedge clk) man_rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            cycles(1);
            if (rst_out) begin
                check("R3 glitch ignored", 1, 0);
                break;
            end
        end
        check("R3 rst_out after glitch", int'(rst_out), 0);

        // R4: timeout after button release lasts at least T cycles
        @(negedge clk) man_rst_n = 1'b0;
        cycles(40);
        check("R4 held while pressed", int'(rst_out), 1);
        @(negedge clk) man_rst_n = 1'b1;
        edges_to_release(n);
        check("R4 lower bound after release", int'(n >= T + 1), 1);
        check("R4 upper bound after release", int'(n <= T + 1 + 2 + (N + 1) * DIV + 2), 1);

        // R6: external pull-down triggers within four cycles, full timeout
        cycles(5);
        @(negedge clk) force_ext = 1'b1;
        cycles(4);
        check("R6 pin trigger", int'(rst_out), 1);
        @(negedge clk) force_ext = 1'b0;
        cycles(T - 6);
        check("R6 timeout still running", int'(rst_out), 1);
        cycles(20);
        check("R6 released after pin trigger", int'(rst_out), 0);
        check("R5 released polarity", int'(rst_out_n), 1);

        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule